// File: doc/BRIEF.md
# Dual Match-Compare Counter Timer

This block holds two independent up-counters behind one small register window. The first counter advances on a slow tick-enable input, nominally a 32768 Hz strobe. The second advances on a separate fast tick-enable input. Software places a compare value in each timer and turns it on. When a counting step lands on that compare value, the timer raises a single-cycle interrupt pulse. The pulse is meant for a rising-edge-sensitive interrupt input.

Each timer has four word registers. The second timer's registers sit 16 bytes above the first's. A word at byte offset 0x20 holds a write lock that shields both timers from stray writes. Reads are combinational from the current address. Writes take effect on the rising clock edge.

Each timer can also restart from zero whenever it reaches its compare value. This gives a periodic event without any software reload.

Top module: `dual_match_timer`

## Requirements
- R1: After synchronous reset, both counts read 0, both compare values read all ones, both control words read 0, the lock reads 0, and both interrupt outputs are low.
- R2: A count advances by one on each clock edge where its own tick input is high and bit 0 (run) of its control word is set. Otherwise it holds. The slow timer uses `tick_slow` and the fast timer uses `tick_fast`.
- R3: A count at its all-ones value steps to zero.
- R4: Any write to the clear word (offset 0xC within a timer) zeroes that timer's count on that edge, taking precedence over a step. The clear word reads as 0.
- R5: With bit 1 (restart) of the control word set, a step taken while the count equals the compare value loads zero instead of count+1.
- R6: When a step produces a count equal to the compare value held before that edge, that timer's interrupt output is high for the one cycle after the edge. That is the same cycle in which the count reads that value.
- R7: The interrupt fires only from a step. Writing a compare value equal to the current count, clearing the count onto the compare value, or leaving a matching timer stopped never raises it.
- R8: Word layout: slow timer at 0x00, fast timer at 0x10. Within a timer, compare is at +0x0, count at +0x4 (read-only, writes ignored), control at +0x8 and clear at +0xC. Compare and control read back what was written. Control uses bits 1:0 only.
- R9: The lock is at 0x20, bit 0. While it is set, writes to every timer word are ignored. The lock itself stays writable and reads back.
- R10: Accesses with byte address bits 1:0 not zero, and accesses to unmapped addresses, write nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_slow | input | 1 | Count enable strobe of the slow timer |
| tick_fast | input | 1 | Count enable strobe of the fast timer |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_slow | output | 1 | Slow timer match pulse |
| irq_fast | output | 1 | Fast timer match pulse |

## Verification
The bench targets the cases where timing or precedence is easy to get wrong.

- **Wrap through all ones.** A counter that saturates would stay there, and one that skips the top value would miss an all-ones compare.
- **Restart on match.** A design that zeroes one step late would read compare+1.
- **Match-write equality.** A design keyed on plain equality rather than on a step would fire when software writes the current count as the compare value, or would fire repeatedly while stopped.
- **Lock.** The lock is checked against every timer word. A design that also locked its own register could never be unlocked.
- **Random traffic.** Random ticks and writes, with compare values placed just ahead of the count, check that each pulse lands in the same cycle as the matching count.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    localparam int NUM_CH       = 2;
    localparam int CH_IDX_W     = 1;
    localparam int CH_STRIDE_SH = 4;   // timers are 16 bytes apart
    localparam int LOCK_OFS     = 32;  // byte offset of the lock word
    localparam int RUN_BIT      = 0;
    localparam int RESTART_BIT  = 1;

    typedef enum logic [1:0] {
        REG_CMP   = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CLEAR = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wr_cmp;
        logic wr_ctrl;
        logic wr_clear;
    } ch_wr_t;

    function automatic logic [31:0] pack_ctrl(input logic run, input logic restart);
        logic [31:0] v;
        v = '0;
        v[RUN_BIT]     = run;
        v[RESTART_BIT] = restart;
        return v;
    endfunction

endpackage

// File: rtl/dmt_decode.sv
module dmt_decode
    import dmt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          lock_on,
    output ch_wr_t [NUM_CH-1:0]           ch_wr,
    output logic                          lock_wr,
    output logic                          hit_ch,
    output logic [CH_IDX_W-1:0]           sel_ch,
    output reg_sel_e                      sel_reg,
    output logic                          hit_lock
);
    localparam int HI_W = ADDR_W - CH_STRIDE_SH;
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(LOCK_OFS);

    logic          aligned;
    logic [HI_W-1:0] hi_part;

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        hi_part  = addr[ADDR_W-1:CH_STRIDE_SH];
        hit_ch   = aligned && (hi_part < HI_W'(NUM_CH));
        sel_ch   = addr[CH_STRIDE_SH +: CH_IDX_W];
        sel_reg  = reg_sel_e'(addr[3:2]);
        hit_lock = aligned && (addr == LOCK_ADDR);
        lock_wr  = wr_en && hit_lock;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch_wr
        logic sel_this;
        assign sel_this           = wr_en && !lock_on && hit_ch && (sel_ch == CH_IDX_W'(i));
        assign ch_wr[i].wr_cmp    = sel_this && (sel_reg == REG_CMP);
        assign ch_wr[i].wr_ctrl   = sel_this && (sel_reg == REG_CTRL);
        assign ch_wr[i].wr_clear  = sel_this && (sel_reg == REG_CLEAR);
    end

endmodule

// File: rtl/dmt_channel.sv
module dmt_channel
    import dmt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  ch_wr_t            wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  cmp,
    output logic              run,
    output logic              restart,
    output logic              irq
);
    logic             stepping;
    logic [CNT_W-1:0] step_val;

    always_comb begin
        stepping = run && tick;
        if (restart && (count == cmp))
            step_val = '0;
        else
            step_val = count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            cmp     <= '1;
            run     <= 1'b0;
            restart <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (wr.wr_cmp)
                cmp <= wdata[CNT_W-1:0];
            if (wr.wr_ctrl) begin
                run     <= wdata[RUN_BIT];
                restart <= wdata[RESTART_BIT];
            end
            if (wr.wr_clear) begin
                count <= '0;
            end else if (stepping) begin
                count <= step_val;
                irq   <= (step_val == cmp);
            end
        end
    end

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr.wr_clear) |-> (count == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(run) && !$past(wr.wr_clear)) |-> $stable(count));

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        $past(run && tick && !wr.wr_clear && !(restart && (count == cmp)))
        |-> (count == CNT_W'($past(count) + 1'b1)));

    // R6
    irq_on_match_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (count == $past(cmp)));

    // R7
    irq_needs_step_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(run && tick));

endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
    import dmt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_slow,
    output logic              irq_fast
);
    ch_wr_t [NUM_CH-1:0]           ch_wr;
    logic                          lock_on;
    logic                          lock_wr;
    logic                          hit_ch;
    logic                          hit_lock;
    logic [CH_IDX_W-1:0]           sel_ch;
    reg_sel_e                      sel_reg;
    logic [NUM_CH-1:0]             ticks;
    logic [NUM_CH-1:0]             irqs;
    logic [NUM_CH-1:0]             runs;
    logic [NUM_CH-1:0]             restarts;
    logic [NUM_CH-1:0][CNT_W-1:0]  counts;
    logic [NUM_CH-1:0][CNT_W-1:0]  cmps;

    assign ticks = {tick_fast, tick_slow};

    dmt_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .lock_on  (lock_on),
        .ch_wr    (ch_wr),
        .lock_wr  (lock_wr),
        .hit_ch   (hit_ch),
        .sel_ch   (sel_ch),
        .sel_reg  (sel_reg),
        .hit_lock (hit_lock)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_timer
        dmt_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (ticks[i]),
            .wr      (ch_wr[i]),
            .wdata   (bus_wdata),
            .count   (counts[i]),
            .cmp     (cmps[i]),
            .run     (runs[i]),
            .restart (restarts[i]),
            .irq     (irqs[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            lock_on <= 1'b0;
        else if (lock_wr)
            lock_on <= bus_wdata[0];
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ch) begin
            unique case (sel_reg)
                REG_CMP:   bus_rdata = DATA_W'(cmps[sel_ch]);
                REG_COUNT: bus_rdata = DATA_W'(counts[sel_ch]);
                REG_CTRL:  bus_rdata = DATA_W'(pack_ctrl(runs[sel_ch], restarts[sel_ch]));
                REG_CLEAR: bus_rdata = '0;
                default:   bus_rdata = '0;
            endcase
        end else if (hit_lock) begin
            bus_rdata = DATA_W'(lock_on);
        end
    end

    assign irq_slow = irqs[0];
    assign irq_fast = irqs[1];

    // R9
    lock_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        lock_on |-> (ch_wr == '0));

    // R9
    lock_writable_chk: assert property (@(posedge clk) disable iff (rst)
        $past(lock_wr) |-> (lock_on == $past(bus_wdata[0])));

endmodule

// File: tb/dual_match_timer_tb.sv
module dual_match_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW   = 10;
    localparam int MASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_slow = 1'b0;
    logic        tick_fast = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_slow;
    logic        irq_fast;

    int n_cmp = 0;
    int n_bad = 0;

    int m_count [2];
    int m_cmp   [2];
    int m_run   [2];
    int m_rst   [2];
    int m_lock;
    int m_irq   [2];
    int irq_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_match_timer #(.CNT_W(CW), .DATA_W(32), .ADDR_W(6)) u_dut (
        .clk(clk), .rst(rst), .tick_slow(tick_slow), .tick_fast(tick_fast),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_slow(irq_slow), .irq_fast(irq_fast)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_read(input int a);
        int ch, r;
        if ((a & 3) != 0) return 0;
        if (a == 32) return m_lock;
        if (a >= 32) return 0;
        ch = a >> 4;
        r  = (a >> 2) & 3;
        case (r)
            0: return m_cmp[ch];
            1: return m_count[ch];
            2: return m_run[ch] | (m_rst[ch] << 1);
            default: return 0;
        endcase
    endfunction

    // one clock: inputs applied at a falling edge, results compared at the next
    task automatic cycle(input bit wr, input int a, input int d, input bit ts, input bit tf);
        int  nc[2], ncmp[2], nrun[2], nrst[2], nirq[2], nlock;
        bit  tk[2];
        int  sv;
        tk[0] = ts; tk[1] = tf;
        nlock = m_lock;
        for (int i = 0; i < 2; i++) begin
            nc[i] = m_count[i]; ncmp[i] = m_cmp[i];
            nrun[i] = m_run[i]; nrst[i] = m_rst[i]; nirq[i] = 0;
            if (m_run[i] != 0 && tk[i]) begin
                sv = (m_rst[i] != 0 && m_count[i] == m_cmp[i]) ? 0 : ((m_count[i] + 1) & MASK);
                nc[i] = sv;
                nirq[i] = (sv == m_cmp[i]) ? 1 : 0;
            end
        end
        if (wr && (a & 3) == 0) begin
            if (a == 32) nlock = d & 1;
            else if (a < 32 && m_lock == 0) begin
                case ((a >> 2) & 3)
                    0: ncmp[a >> 4] = d & MASK;
                    2: begin nrun[a >> 4] = d & 1; nrst[a >> 4] = (d >> 1) & 1; end
                    3: begin nc[a >> 4] = 0; nirq[a >> 4] = 0; end
                    default: ;
                endcase
            end
        end
        bus_wr = wr; bus_addr = 6'(a); bus_wdata = d;
        tick_slow = ts; tick_fast = tf;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            m_count[i] = nc[i]; m_cmp[i] = ncmp[i];
            m_run[i] = nrun[i]; m_rst[i] = nrst[i]; m_irq[i] = nirq[i];
        end
        m_lock = nlock;
        irq_seen += int'(irq_slow) + int'(irq_fast);
        check("R6 irq_slow", int'(irq_slow), m_irq[0]);
        check("R6 irq_fast", int'(irq_fast), m_irq[1]);
        bus_wr = 1'b0; tick_slow = 1'b0; tick_fast = 1'b0;
    endtask

    task automatic rd(input string tag, input int a, input int exp);
        bus_wr = 1'b0;
        bus_addr = 6'(a);
        #1;
        check(tag, int'(bus_rdata), exp);
    endtask

    task automatic wrw(input int a, input int d);
        cycle(1'b1, a, d, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int a, d, r;
        void'($urandom(32'd1234));
        for (int i = 0; i < 2; i++) begin
            m_count[i] = 0; m_cmp[i] = MASK; m_run[i] = 0; m_rst[i] = 0; m_irq[i] = 0;
        end
        m_lock = 0;
        irq_seen = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd("R1 cmp0", 8'h00, MASK);
        rd("R1 cmp1", 8'h10, MASK);
        rd("R1 count0", 8'h04, 0);
        rd("R1 ctrl1", 8'h18, 0);
        rd("R1 lock", 8'h20, 0);
        check("R1 irq", int'(irq_slow) + int'(irq_fast), 0);

        // R2 counting with separate ticks
        wrw(8'h08, 1);
        repeat (5) cycle(1'b0, 0, 0, 1'b1, 1'b1);
        rd("R2 slow advanced", 8'h04, 5);
        rd("R2 fast stopped", 8'h14, 0);
        repeat (3) cycle(1'b0, 0, 0, 1'b0, 1'b1);
        rd("R2 slow holds without tick", 8'h04, 5);

        // R7 compare equal to count: no pulse
        irq_seen = 0;
        wrw(8'h00, 5);
        repeat (4) cycle(1'b0, 0, 0, 1'b0, 1'b0);
        check("R7 no pulse on compare write", irq_seen, 0);
        // R6 step onto compare
        wrw(8'h00, 8);
        cycle(1'b0, 0, 0, 1'b1, 1'b0);
        cycle(1'b0, 0, 0, 1'b1, 1'b0);
        cycle(1'b0, 0, 0, 1'b1, 1'b0);
        check("R6 pulse with count 8", int'(irq_slow), 1);
        rd("R6 count at pulse", 8'h04, 8);
        cycle(1'b0, 0, 0, 1'b0, 1'b0);
        check("R6 pulse one cycle", int'(irq_slow), 0);
        // R7 stopped on match, and clear onto compare 0
        irq_seen = 0;
        wrw(8'h08, 0);
        repeat (3) cycle(1'b0, 0, 0, 1'b1, 1'b0);
        wrw(8'h00, 0);
        wrw(8'h0C, 7);
        check("R7 no pulse stopped or on clear", irq_seen, 0);
        rd("R4 clear zeroes", 8'h04, 0);
        rd("R4 clear reads 0", 8'h0C, 0);

        // R5 restart on match
        wrw(8'h00, 10);
        wrw(8'h08, 3);
        rd("R8 ctrl readback", 8'h08, 3);
        irq_seen = 0;
        repeat (12) cycle(1'b0, 0, 0, 1'b1, 1'b0);
        rd("R5 restart count", 8'h04, 1);
        check("R5 single pulse", irq_seen, 1);

        // R3 wrap of fast timer through all ones
        wrw(8'h1C, 0);
        wrw(8'h18, 1);
        irq_seen = 0;
        repeat (MASK) cycle(1'b0, 0, 0, 1'b0, 1'b1);
        rd("R3 at all ones", 8'h14, MASK);
        check("R3 pulse at all ones", irq_seen, 1);
        cycle(1'b0, 0, 0, 1'b0, 1'b1);
        rd("R3 wrapped", 8'h14, 0);

        // R8 count is read-only
        wrw(8'h14, 77);
        rd("R8 count write ignored", 8'h14, 0);

        // R9 lock
        wrw(8'h20, 1);
        rd("R9 lock set", 8'h20, 1);
        wrw(8'h10, 8'h55);
        wrw(8'h08, 0);
        rd("R9 cmp locked", 8'h10, MASK);
        rd("R9 ctrl locked", 8'h08, 3);
        wrw(8'h20, 0);
        rd("R9 lock cleared", 8'h20, 0);
        wrw(8'h10, 8'h55);
        rd("R9 write after unlock", 8'h10, 8'h55);

        // R10 misaligned and unmapped
        wrw(8'h11, 8'h22);
        rd("R10 misaligned write ignored", 8'h10, 8'h55);
        rd("R10 misaligned read", 8'h11, 0);
        wrw(8'h24, 1);
        rd("R10 unmapped read", 8'h24, 0);
        rd("R10 lock untouched", 8'h20, 0);

        // random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            r = $urandom % 8;
            if (r == 0) begin
                a = ($urandom % 10) * 4;
                if (a == 32 && ($urandom % 4) != 0) d = 0;
                else if (((a >> 2) & 3) == 0 && a < 32)
                    d = (m_count[a >> 4] + 1 + $urandom % 6) & MASK;
                else d = $urandom;
                cycle(1'b1, a, d, 1'($urandom % 4 == 0), 1'($urandom % 4 != 0));
            end else begin
                cycle(1'b0, 0, 0, 1'($urandom % 4 == 0), 1'($urandom % 4 != 0));
            end
            if (k % 4 == 0) begin
                a = $urandom % 64;
                if ($urandom % 2 == 0) a = a & 6'h3C;
                rd("R8 random read", a, exp_read(a));
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule